// File: doc/BRIEF.md
# Second-Order Digital Delta-Sigma Modulator

This block turns a stream of signed multi-bit fixed-point samples into a single-bit pulse-density stream. It uses two integrators in series. The first integrator accumulates the input sample. The second integrator accumulates the first one's value. Both integrators also subtract the current 1-bit decision, taken as plus or minus one integer unit, so that over time the density of ones follows the input level.

All words are 24-bit two's complement: 1 sign bit, 7 integer bits and 16 fraction bits. The feedback of plus or minus one therefore enters only the top byte of each integrator. The integrators wrap modulo 2^24 and carry no guard bits. The quantizer is the inverted sign of the second integrator, so a logic 1 stands for +1 and a logic 0 stands for -1.

A sample-enable strobe advances the loop by one step. The output bit is registered and appears on the cycle after the strobe. The value of the second integrator is available on an observation port.

Top module: `dsm2_modulator`

## Requirements
- R1: On each cycle with `sampleEn` high, the first integrator becomes its old value plus `sampleIn` minus q·2^16. Here q is +1 when the second integrator is non-negative and -1 when it is negative. The first integrator is seen through its effect on `lastIntegrator` one strobe later.
- R2: On each strobe, `lastIntegrator` becomes its old value plus the old value of the first integrator, minus q·2^16.
- R3: On the cycle after a strobe, `pdmOut` is 1 if `lastIntegrator` was non-negative (bit 23 = 0) before that strobe, and 0 if it was negative.
- R4: The feedback changes only bits 23:16. Bits 15:0 of an integrator advance by exactly the fraction bits of its addend, modulo 2^16.
- R5: Integrator arithmetic wraps modulo 2^24. It never saturates, even with a full-scale input held constant.
- R6: On a cycle with `sampleEn` low, `pdmOut` and `lastIntegrator` keep their values.
- R7: A synchronous reset (`rst` high at a clock edge) sets both integrators to zero and sets `pdmOut` to 0. `rst` takes priority over `sampleEn`.
- R8: For a constant input of v integer units, with |v| < 1, the fraction of ones over 1024 strobes is within 6/1024 of (1+v)/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | Sample strobe that advances the modulator one step |
| sampleIn | input | 24 | Signed sample, 1.7.16 fixed point |
| pdmOut | output | 1 | Registered 1-bit output, 1 = +1, 0 = -1 |
| lastIntegrator | output | 24 | Current value of the second integrator |

## Verification
The assertions assume that `sampleIn` is stable on each cycle where `sampleEn` is high. They also assume that `rst` is held high from the first clock edge, so that every register has a known value before any `$past` comparison counts. The bench drives all inputs on the falling edge and asserts reset before any strobe. It follows a reference loop computed in plain modulo-2^24 arithmetic. The stimulus includes gapped and random strobes, a full-scale input that forces wrap-around, and a reset applied while a strobe is high.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;
  localparam int WORD_W  = 24;
  localparam int FRAC_W  = 16;
  localparam int STAGES  = 2;
  localparam int UPPER_W = WORD_W - FRAC_W;

  typedef struct packed {
    logic clear;
    logic advance;
  } dsmStrobes_t;
endpackage

// File: rtl/dsm2_ctrl.sv
module dsm2_ctrl
  import dsm2_pkg::*;
(
  input  logic        rst,
  input  logic        sampleEn,
  output dsmStrobes_t strobes
);
  always_comb begin
    strobes.clear   = rst;
    strobes.advance = sampleEn & ~rst;
  end
endmodule

// File: rtl/dsm2_integrator.sv
module dsm2_integrator #(
  parameter int W    = 24,
  parameter int FRAC = 16
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         advance,
  input  logic [W-1:0] addend,
  input  logic         fbPos,     // 1: feedback +1, 0: feedback -1
  output logic [W-1:0] state
);
  localparam int UP_W = W - FRAC;

  logic [FRAC:0]   lowSum;
  logic [UP_W-1:0] fbVal;
  logic [UP_W-1:0] highSum;

  always_comb begin
    lowSum  = {1'b0, state[FRAC-1:0]} + {1'b0, addend[FRAC-1:0]};
    fbVal   = fbPos ? UP_W'(1) : '1;
    highSum = state[W-1:FRAC] + addend[W-1:FRAC]
            + {{(UP_W-1){1'b0}}, lowSum[FRAC]} + fbVal;
  end

  always_ff @(posedge clk) begin
    if (clear)        state <= '0;
    else if (advance) state <= {highSum, lowSum[FRAC-1:0]};
  end

  // R4: feedback never reaches the fraction bits
  assert_fraction_only_input_R4: assert property (@(posedge clk) disable iff (clear)
    advance |=> state[FRAC-1:0] == $past(state[FRAC-1:0] + addend[FRAC-1:0]));

  // R6: integrator holds without a strobe
  assert_hold_without_strobe_R6: assert property (@(posedge clk) disable iff (clear)
    !advance |=> $stable(state));
endmodule

// File: rtl/dsm2_datapath.sv
module dsm2_datapath
  import dsm2_pkg::*;
(
  input  logic              clk,
  input  dsmStrobes_t       strobes,
  input  logic [WORD_W-1:0] sampleIn,
  output logic              pdmOut,
  output logic [WORD_W-1:0] lastIntegrator
);
  logic [WORD_W-1:0] intState  [STAGES];
  logic [WORD_W-1:0] intAddend [STAGES];
  logic              lastNeg;

  assign lastNeg = intState[STAGES-1][WORD_W-1];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      assign intAddend[s] = sampleIn;
    end else begin : gChain
      assign intAddend[s] = intState[s-1];
    end
    dsm2_integrator #(.W(WORD_W), .FRAC(FRAC_W)) uInt (
      .clk    (clk),
      .clear  (strobes.clear),
      .advance(strobes.advance),
      .addend (intAddend[s]),
      .fbPos  (lastNeg),
      .state  (intState[s])
    );
  end

  always_ff @(posedge clk) begin
    if (strobes.clear)        pdmOut <= 1'b0;
    else if (strobes.advance) pdmOut <= ~lastNeg;
  end

  assign lastIntegrator = intState[STAGES-1];

  // R6: output bit holds without a strobe
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.advance |=> $stable(pdmOut));
endmodule

// File: rtl/dsm2_modulator.sv
module dsm2_modulator
  import dsm2_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleEn,
  input  logic [WORD_W-1:0] sampleIn,
  output logic              pdmOut,
  output logic [WORD_W-1:0] lastIntegrator
);
  dsmStrobes_t strobes;

  dsm2_ctrl uCtrl (
    .rst     (rst),
    .sampleEn(sampleEn),
    .strobes (strobes)
  );

  dsm2_datapath uPath (
    .clk           (clk),
    .strobes       (strobes),
    .sampleIn      (sampleIn),
    .pdmOut        (pdmOut),
    .lastIntegrator(lastIntegrator)
  );

  // R3: output is the inverted sign of the second integrator before the strobe
  assert_quantizer_sign_R3: assert property (@(posedge clk) disable iff (rst)
    sampleEn |=> pdmOut == ~$past(lastIntegrator[WORD_W-1]));

  // R7: leaving reset finds a cleared loop
  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lastIntegrator == '0) && !pdmOut);
endmodule

// File: tb/dsm2_modulator_test.sv
module dsm2_modulator_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleEn = 1'b0;
  logic [23:0] sampleIn = '0;
  logic        pdmOut;
  logic [23:0] lastIntegrator;

  int checks = 0;
  int failures = 0;
  logic [23:0] m1, m2;
  logic        mOut;
  int          ones;

  always #10 clk = ~clk;   // 50 MHz

  dsm2_modulator uut (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .sampleIn(sampleIn),
    .pdmOut(pdmOut), .lastIntegrator(lastIntegrator)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    m1 = '0; m2 = '0; mOut = 1'b0;
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(input string tag, input logic en, input logic [23:0] v);
    logic [23:0] fb;
    sampleEn = en;
    sampleIn = v;
    if (en) begin
      fb   = m2[23] ? 24'h010000 : 24'hFF0000;
      mOut = ~m2[23];
      m2   = m2 + m1 + fb;
      m1   = m1 + v + fb;
    end
    @(negedge clk);
    check({tag, " R2 integrator"}, lastIntegrator, m2);
    check("R3 output bit", {23'd0, pdmOut}, {23'd0, mOut});
    if (en && pdmOut) ones++;
  endtask

  task automatic doReset();
    rst = 1'b1; sampleEn = 1'b1; sampleIn = 24'h123456;
    @(negedge clk);
    rst = 1'b0; sampleEn = 1'b0;
    modelReset();
    check("R7 reset integrator", lastIntegrator, 24'h0);
    check("R7 reset output", {23'd0, pdmOut}, 24'h0);
  endtask

  task automatic density(input logic [23:0] v, input int expOnes);
    int d;
    doReset();
    ones = 0;
    for (int i = 0; i < 1024; i++) step("R8 R1", 1'b1, v);
    d = ones - expOnes;
    checks++;
    if (d > 6 || d < -6) begin
      failures++;
      $display("FAIL R8 density ones actual=%0d expected=%0d", ones, expOnes);
    end
  endtask

  initial begin
    logic [23:0] lfsr;
    logic [23:0] held;
    modelReset();
    @(negedge clk);
    @(negedge clk);
    doReset();

    // R1/R2/R3: simple patterns with continuous strobes
    for (int i = 0; i < 40; i++) step("R1", 1'b1, 24'h008000);
    for (int i = 0; i < 40; i++) step("R1", 1'b1, 24'hFF4000);

    // R6: strobe low holds everything
    held = lastIntegrator;
    for (int i = 0; i < 8; i++) step("R6 hold", 1'b0, 24'h7FFFFF);
    check("R6 held integrator", lastIntegrator, held);

    // R5: full-scale constant input wraps the integrators
    doReset();
    for (int i = 0; i < 300; i++) step("R5 wrap", 1'b1, 24'h7F0000);
    for (int i = 0; i < 300; i++) step("R5 wrap", 1'b1, 24'h800000);

    // R4/R1: random inputs, random strobes, random fractions
    doReset();
    lfsr = 24'hACE1B5;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      step("R4 R1 random", lfsr[3] | lfsr[9], lfsr);
    end

    // R8: density tracks DC level
    density(24'h004000, 640);   // +0.25
    density(24'hFF8000, 256);   // -0.5
    density(24'h000000, 512);   // 0

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule